// File: doc/BRIEF.md
# Reconfigurable Four-Function Test Register

This block is an N-bit register meant to sit between two pieces of logic. A two-bit mode code selects one of four functions. It can work as a serial scan chain. It can work as a free-running pseudo-random pattern source. It can compact a parallel response word into a signature. It can also be an ordinary parallel-load register for functional operation. One physical register therefore serves functional traffic and self-test without extra flops. A separate sequencer, outside this block, changes the mode of each such register in turn.

During a self-test of one logic block, the register that feeds that block's inputs runs as the pattern source. The register that captures its outputs runs as the signature compactor. Both the pattern source and the compactor use the same primitive feedback polynomial, so the pattern source visits every nonzero state once per period. Reset seeds the register with a nonzero value, so pattern generation can start at once. If pattern mode begins from the all-zero state, the register escapes that state on the next clock.

Top module: `multimode_test_reg`

## Requirements
- R1: While `rst` is high, on each clock edge the register loads `SEED` (default 0x01), so `reg_out` reads 0x01 and `scan_out` reads 0.
- R2: With mode code {`mode_hi`,`mode_lo`} = 2'b10 (functional load), `reg_out` equals the `par_in` value sampled on the previous clock edge.
- R3: With mode code 2'b00 (scan), bit 0 takes `scan_in` and every other bit k takes the previous bit k-1 on each clock.
- R4: With mode code 2'b01 (pattern source) and a nonzero state, the next state is {state[W-2:0], fb}. Here fb is the XOR of the state bits selected by `TAP_MASK` (default 0xB8, bits 7,5,4,3, for x^8+x^6+x^5+x^4+1). `par_in` and `scan_in` have no effect in this mode.
- R5: In pattern-source mode, starting from a nonzero seed, the state is never zero, and it first returns to the seed after exactly 2^W-1 = 255 clocks.
- R6: If pattern-source mode is clocked while the state is all zeros, the next state is 0x01.
- R7: With mode code 2'b11 (signature), the next state is {state[W-2:0], fb} XOR `par_in`, with fb as in R4.
- R8: In signature mode the all-zero state is not forced. A zero state with a zero `par_in` stays zero.
- R9: `scan_out` always equals bit W-1 of `reg_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, loads the seed |
| mode_hi | input | 1 | Upper bit of the mode code |
| mode_lo | input | 1 | Lower bit of the mode code |
| par_in | input | W | Parallel data / response input |
| scan_in | input | 1 | Serial input into bit 0 in scan mode |
| reg_out | output | W | Register contents |
| scan_out | output | 1 | Serial output, top bit of the register |

## Verification
A wrong feedback tap or a wrong bit order shows on `reg_out` on the first clock in pattern or signature mode. The bench therefore compares every state in those modes with an independently computed next state. A subtler error, such as a non-maximal polynomial or a missing zero-escape, might not change the first step. It does show up as a wrong period or a stuck zero within one 255-cycle sweep. Scan-path errors reach `scan_out` within W clocks of shifting.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

  // Mode code {mode_hi, mode_lo}
  typedef enum logic [1:0] {
    MODE_SCAN = 2'b00,
    MODE_PRPG = 2'b01,
    MODE_LOAD = 2'b10,
    MODE_MISR = 2'b11
  } mode_e;

endpackage

// File: rtl/mtr_mode_dec.sv
module mtr_mode_dec
  import mtr_pkg::*;
(
  input  logic mode_hi,
  input  logic mode_lo,
  output logic sel_scan,
  output logic sel_prpg,
  output logic sel_misr,
  output logic sel_load
);

  mode_e mode;
  assign mode = mode_e'({mode_hi, mode_lo});

  always_comb begin
    sel_scan = 1'b0;
    sel_prpg = 1'b0;
    sel_misr = 1'b0;
    sel_load = 1'b0;
    unique case (mode)
      MODE_SCAN: sel_scan = 1'b1;
      MODE_PRPG: sel_prpg = 1'b1;
      MODE_MISR: sel_misr = 1'b1;
      MODE_LOAD: sel_load = 1'b1;
      default:   sel_load = 1'b1;
    endcase
  end

endmodule

// File: rtl/mtr_feedback.sv
module mtr_feedback #(
  parameter int unsigned          W        = 8,
  parameter logic [W-1:0]         TAP_MASK = 8'hB8
) (
  input  logic [W-1:0] state,
  output logic         fb,
  output logic         is_zero
);

  logic [W-1:0] tapped;
  assign tapped  = state & TAP_MASK;
  assign fb      = ^tapped;
  assign is_zero = (state == '0);

endmodule

// File: rtl/mtr_cell.sv
module mtr_cell (
  input  logic sel_load,
  input  logic sel_misr,
  input  logic shift_in,
  input  logic par_bit,
  output logic nxt
);

  // Load takes the parallel bit; otherwise shift, optionally folding in data.
  always_comb begin
    if (sel_load)      nxt = par_bit;
    else if (sel_misr) nxt = shift_in ^ par_bit;
    else               nxt = shift_in;
  end

endmodule

// File: rtl/multimode_test_reg.sv
module multimode_test_reg #(
  parameter int unsigned  W        = 8,
  parameter logic [W-1:0] TAP_MASK = 8'hB8,
  parameter logic [W-1:0] SEED     = 8'h01
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_hi,
  input  logic         mode_lo,
  input  logic [W-1:0] par_in,
  input  logic         scan_in,
  output logic [W-1:0] reg_out,
  output logic         scan_out
);

  localparam int unsigned TOP = W - 1;

  logic sel_scan, sel_prpg, sel_misr, sel_load;
  logic fb, is_zero;
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic [W-1:0] shift_src;

  mtr_mode_dec u_dec (
    .mode_hi (mode_hi),
    .mode_lo (mode_lo),
    .sel_scan(sel_scan),
    .sel_prpg(sel_prpg),
    .sel_misr(sel_misr),
    .sel_load(sel_load)
  );

  mtr_feedback #(.W(W), .TAP_MASK(TAP_MASK)) u_fb (
    .state  (state_q),
    .fb     (fb),
    .is_zero(is_zero)
  );

  // Bit 0 entry: serial data in scan mode, feedback otherwise; the
  // pattern source escapes the all-zero lock by injecting a one.
  assign shift_src[0] = sel_scan ? scan_in : (fb | (sel_prpg & is_zero));

  genvar i;
  generate
    for (i = 1; i < W; i++) begin : g_chain
      assign shift_src[i] = state_q[i-1];
    end
    for (i = 0; i < W; i++) begin : g_cell
      mtr_cell u_cell (
        .sel_load(sel_load),
        .sel_misr(sel_misr),
        .shift_in(shift_src[i]),
        .par_bit (par_in[i]),
        .nxt     (state_d[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= state_d;
  end

  assign reg_out  = state_q;
  assign scan_out = state_q[TOP];

endmodule

// File: rtl/mtr_checker.sv
module mtr_checker #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input logic         clk,
  input logic         rst,
  input logic         mode_hi,
  input logic         mode_lo,
  input logic [W-1:0] par_in,
  input logic         scan_in,
  input logic [W-1:0] reg_out,
  input logic         scan_out
);

  logic [1:0] m;
  assign m = {mode_hi, mode_lo};

  // R1
  p_seed_r1: assert property (@(posedge clk) rst |=> reg_out == SEED);

  // R2
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    m == 2'b10 |=> reg_out == $past(par_in));

  // R3
  p_scan_r3: assert property (@(posedge clk) disable iff (rst)
    m == 2'b00 |=> reg_out == {$past(reg_out[W-2:0]), $past(scan_in)});

  // R4
  p_prpg_shift_r4: assert property (@(posedge clk) disable iff (rst)
    m == 2'b01 |=> reg_out[W-1:1] == $past(reg_out[W-2:0]));

  // R5 / R6
  p_prpg_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    m == 2'b01 |=> reg_out != '0);

  // R7
  p_misr_r7: assert property (@(posedge clk) disable iff (rst)
    m == 2'b11 |=> reg_out[W-1:1] == ($past(reg_out[W-2:0]) ^ $past(par_in[W-1:1])));

  // R8
  p_misr_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (m == 2'b11 && reg_out == '0 && par_in == '0) |=> reg_out == '0);

  // R9
  p_scanout_r9: assert property (@(posedge clk) disable iff (rst)
    scan_out == reg_out[W-1]);

endmodule

bind multimode_test_reg mtr_checker #(.W(W), .SEED(SEED)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mode_hi (mode_hi),
  .mode_lo (mode_lo),
  .par_in  (par_in),
  .scan_in (scan_in),
  .reg_out (reg_out),
  .scan_out(scan_out)
);

// File: tb/multimode_test_reg_tb.sv
module multimode_test_reg_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_hi = 1'b0;
  logic         mode_lo = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         scan_in = 1'b0;
  logic [W-1:0] reg_out;
  logic         scan_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  multimode_test_reg dut_i (
    .clk(clk), .rst(rst), .mode_hi(mode_hi), .mode_lo(mode_lo),
    .par_in(par_in), .scan_in(scan_in), .reg_out(reg_out), .scan_out(scan_out)
  );

  function automatic logic [W-1:0] next_fb(input logic [W-1:0] s);
    // x^8+x^6+x^5+x^4+1 : stages 8,6,5,4 -> bits 7,5,4,3
    return {s[W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_hi = m[1];
    mode_lo = m[0];
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load_val(input logic [W-1:0] v);
    set_mode(2'b10); par_in = v; tick();
  endtask

  task automatic t_reset();
    chk("R1 reg_out", reg_out, 8'h01);
    chk("R1 scan_out", {7'b0, scan_out}, 8'h00);
    rst = 1'b0;
  endtask

  task automatic t_load();
    load_val(8'h5C); chk("R2 load 5C", reg_out, 8'h5C);
    load_val(8'hFF); chk("R2 load FF", reg_out, 8'hFF);
    chk("R9 scan_out top", {7'b0, scan_out}, 8'h01);
    load_val(8'h00); chk("R2 load 00", reg_out, 8'h00);
  endtask

  task automatic t_scan();
    logic [W-1:0] exp;
    logic [7:0] bits;
    bits = 8'b1101_1001;
    load_val(8'hA5);
    exp = 8'hA5;
    set_mode(2'b00);
    par_in = 8'h3C;
    for (int k = 0; k < 8; k++) begin
      scan_in = bits[k];
      tick();
      exp = {exp[W-2:0], bits[k]};
      chk("R3 scan shift", reg_out, exp);
      chk("R9 scan_out", {7'b0, scan_out}, {7'b0, exp[W-1]});
    end
    scan_in = 1'b0;
  endtask

  task automatic t_prpg_period();
    logic [W-1:0] exp;
    int first_ret;
    load_val(8'h01);
    exp = 8'h01;
    first_ret = -1;
    set_mode(2'b01);
    for (int k = 1; k <= 255; k++) begin
      par_in  = 8'(k * 37);
      scan_in = k[0];
      tick();
      exp = next_fb(exp);
      chk("R4 prpg step", reg_out, exp);
      if (reg_out == 8'h00) chk("R5 nonzero", reg_out, 8'h01);
      if (reg_out == 8'h01 && first_ret < 0) first_ret = k;
    end
    chk("R5 period", 8'(first_ret), 8'd255);
  endtask

  task automatic t_zero_lock();
    load_val(8'h00);
    set_mode(2'b01);
    tick();
    chk("R6 zero escape", reg_out, 8'h01);
    tick();
    chk("R4 after escape", reg_out, 8'h02);
  endtask

  task automatic t_misr();
    logic [W-1:0] exp;
    logic [W-1:0] sig_a;
    load_val(8'h01);
    exp = 8'h01;
    set_mode(2'b11);
    for (int k = 0; k < 16; k++) begin
      par_in = 8'(8'h9D ^ (k * 11));
      tick();
      exp = next_fb(exp) ^ (8'h9D ^ 8'(k * 11));
      chk("R7 misr step", reg_out, exp);
    end
    sig_a = exp;
    // Same sequence with one response bit flipped must give another signature
    load_val(8'h01);
    exp = 8'h01;
    set_mode(2'b11);
    for (int k = 0; k < 16; k++) begin
      par_in = 8'(8'h9D ^ (k * 11)) ^ ((k == 5) ? 8'h10 : 8'h00);
      tick();
      exp = next_fb(exp) ^ par_in;
    end
    chk("R7 misr flipped", reg_out, exp);
    n_checks++;
    if (reg_out == sig_a) begin
      n_fail++;
      $display("FAIL R7 signature unchanged actual=%h expected!=%h", reg_out, sig_a);
    end
  endtask

  task automatic t_misr_zero();
    load_val(8'h00);
    set_mode(2'b11);
    par_in = 8'h00;
    tick(); chk("R8 misr zero hold", reg_out, 8'h00);
    tick(); chk("R8 misr zero hold 2", reg_out, 8'h00);
    par_in = 8'h40;
    tick(); chk("R7 misr from zero", reg_out, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_load();
    t_scan();
    t_prpg_period();
    t_zero_lock();
    t_misr();
    t_misr_zero();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule